// File: doc/BRIEF.md
# Prioritized Vectored Interrupt Controller

This block gathers a set of level-sensitive interrupt request lines, numbered from 1 upward, and turns them into one interrupt request for a CPU. The CPU sees it as a 3-bit interrupt level and an 8-bit vector number. Each source has an 8-bit control byte with three fields: a level, a two-bit tie-break priority within that level, and a flag that selects automatic vector generation. A mask word can block any source. Among the unmasked sources that are asserted, the one with the largest combined level-and-priority value wins.

The vector for the winner comes from one of two places. If the winner's auto flag is set, the vector is derived from its level. Otherwise it is a programmable byte: there is one for the watchdog source and one for each of the two serial-port sources, and every other source gets a fixed default. Software reaches the registers over a small synchronous byte/word bus with big-endian lane order. Both outputs are registered, so they follow a change on the request lines or a register write one clock later.

Top module: `prio_vec_intc`

## Requirements
- R1: The pending word at offset 0x3A (word) reads bit i as the value request line i held at the previous clock edge. Bit 0 and unused upper bits read 0. Writes to 0x3A/0x3B have no effect.
- R2: Mask word at 0x36 (word): a 1 in bit i blocks source i. It resets to 0x3FFE, so all 13 sources start blocked. Bit 0 and bits 15:14 always read 0.
- R3: Control byte of source i sits at offset 0x13+i (0x14..0x20): level in bits 4:2, sub-priority in bits 1:0, auto flag in bit 7. The winner is the unmasked asserted source with the largest bits 4:0.
- R4: When two candidates have equal bits 4:0, the lower-numbered source wins.
- R5: If the winner's bits 4:0 are below 4 (level 0), or there is no candidate, both the level and the vector output are 0.
- R6: With the winner's bit 7 set, the vector output is 24 plus its level.
- R7: With bit 7 clear, source 8 uses the watchdog vector byte at 0x42 (reset 0x0F), sources 12 and 13 use the bytes at 0x44 and 0x45 (reset 0x00), and any other source uses 0x0F.
- R8: At reset, the control bytes of sources 1..13 hold 0x04, 0x08, 0x0C, 0x10, 0x14, 0x18, 0x1C, 0x1C, 0x80, 0x80, 0x80, 0x00 and 0x00.
- R9: The level and vector outputs are registered: they show the result for the request lines and registers present before a clock edge, and read 0 during and right after reset.
- R10: Bus access is big-endian. A word access (bus_word=1) ignores address bit 0 and covers the even byte on data bits 15:8 and the odd byte on bits 7:0. A byte access uses data bits 7:0 and returns the byte on read bits 7:0 with bits 15:8 zero. Unmapped bytes read 0 and ignore writes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_wr | input | 1 | Write strobe for the current cycle |
| bus_word | input | 1 | 1 selects a 16-bit access, 0 an 8-bit access |
| bus_addr | input | 8 | Byte offset of the access |
| bus_wdata | input | 16 | Write data |
| bus_rdata | output | 16 | Read data for bus_addr (combinational) |
| irq_src | input | 13 | Request lines; bit i is source i |
| irq_level | output | 3 | Requested interrupt level, 0 when idle |
| irq_vector | output | 8 | Vector number for the request, 0 when idle |

## Verification
A corrupted control byte or mask bit shows up the clock after the affected source becomes the best candidate. At that point the level or vector outputs are wrong, and a read of the register also returns the wrong value right away. A wrong pending bit can only be seen through a read at 0x3A, one clock after the request line changes. A wrong tie-break or auto-flag decode shows up when two sources share a rank or when an auto-flagged source wins. The bench compares its own behavioural model on every clock, so a fault appears at most one clock after the stimulus that exposes it.

// File: rtl/pvi_pkg.sv
package pvi_pkg;
   typedef logic [7:0] ctl_t;

   localparam logic [7:0] CTL_BASE   = 8'h14;
   localparam logic [7:0] MASK_OFF   = 8'h36;
   localparam logic [7:0] PEND_OFF   = 8'h3A;
   localparam logic [7:0] WDV_OFF    = 8'h42;
   localparam logic [7:0] U0V_OFF    = 8'h44;
   localparam logic [7:0] U1V_OFF    = 8'h45;
   localparam logic [7:0] DFLT_VEC   = 8'h0F;
   localparam logic [7:0] AUTO_BASE  = 8'd24;
   localparam logic [4:0] MIN_RANK   = 5'd4;
   localparam int         MAX_SRC    = 15;

   // reset value of a source's control byte
   function automatic ctl_t ctl_reset(input int src);
      if (src >= 1 && src <= 7)       return ctl_t'(src * 4);
      else if (src == 8)              return 8'h1C;
      else if (src >= 9 && src <= 11) return 8'h80;
      else                            return 8'h00;
   endfunction
endpackage

// File: rtl/pvi_regs.sv
module pvi_regs
   import pvi_pkg::*;
#(
   parameter int NUM_SRC = 13
) (
   input  logic                       clk,
   input  logic                       rst_n,
   input  logic                       bus_wr,
   input  logic                       bus_word,
   input  logic [7:0]                 bus_addr,
   input  logic [15:0]                bus_wdata,
   output logic [15:0]                bus_rdata,
   input  logic [NUM_SRC:1]           irq_src,
   output logic [NUM_SRC:1][7:0]      ctl,
   output logic [NUM_SRC:1]           mask,
   output logic [7:0]                 wdog_vec,
   output logic [7:0]                 uart0_vec,
   output logic [7:0]                 uart1_vec
);
   localparam logic [15:0] SRC_BITS = 16'((32'd1 << (NUM_SRC + 1)) - 32'd2);
   localparam logic [7:0]  MASK_LO  = MASK_OFF + 8'd1;

   logic [NUM_SRC:1][7:0] ctl_q;
   logic [15:0]           mask_q;
   logic [15:0]           pend_q;
   logic [7:0]            wdv_q, u0v_q, u1v_q;

   function automatic logic wr_hit(input logic [7:0] off);
      return bus_wr && (bus_word ? (bus_addr[7:1] == off[7:1]) : (bus_addr == off));
   endfunction

   function automatic logic [7:0] wr_lane(input logic [7:0] off);
      return (bus_word && !off[0]) ? bus_wdata[15:8] : bus_wdata[7:0];
   endfunction

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         for (int i = 1; i <= NUM_SRC; i++) ctl_q[i] <= ctl_reset(i);
      end else begin
         for (int i = 1; i <= NUM_SRC; i++)
            if (wr_hit(CTL_BASE + 8'(i - 1))) ctl_q[i] <= wr_lane(CTL_BASE + 8'(i - 1));
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         mask_q <= SRC_BITS;
         wdv_q  <= DFLT_VEC;
         u0v_q  <= 8'h00;
         u1v_q  <= 8'h00;
         pend_q <= 16'h0000;
      end else begin
         pend_q <= 16'({irq_src, 1'b0});
         if (wr_hit(MASK_OFF)) mask_q[15:8] <= wr_lane(MASK_OFF) & SRC_BITS[15:8];
         if (wr_hit(MASK_LO))  mask_q[7:0]  <= wr_lane(MASK_LO)  & SRC_BITS[7:0];
         if (wr_hit(WDV_OFF))  wdv_q <= wr_lane(WDV_OFF);
         if (wr_hit(U0V_OFF))  u0v_q <= wr_lane(U0V_OFF);
         if (wr_hit(U1V_OFF))  u1v_q <= wr_lane(U1V_OFF);
      end
   end

   function automatic logic [7:0] rd_byte(input logic [7:0] off);
      logic [7:0] r;
      r = 8'h00;
      if (off == MASK_OFF)              r = mask_q[15:8];
      if (off == MASK_LO)               r = mask_q[7:0];
      if (off == PEND_OFF)              r = pend_q[15:8];
      if (off == (PEND_OFF | 8'h01))    r = pend_q[7:0];
      if (off == WDV_OFF)               r = wdv_q;
      if (off == U0V_OFF)               r = u0v_q;
      if (off == U1V_OFF)               r = u1v_q;
      for (int i = 1; i <= NUM_SRC; i++)
         if (off == CTL_BASE + 8'(i - 1)) r = ctl_q[i];
      return r;
   endfunction

   always_comb begin
      if (bus_word) bus_rdata = {rd_byte({bus_addr[7:1], 1'b0}), rd_byte({bus_addr[7:1], 1'b1})};
      else          bus_rdata = {8'h00, rd_byte(bus_addr)};
   end

   assign ctl       = ctl_q;
   assign mask      = mask_q[NUM_SRC:1];
   assign wdog_vec  = wdv_q;
   assign uart0_vec = u0v_q;
   assign uart1_vec = u1v_q;

   AST_PEND_TRACKS: assert property (@(posedge clk) disable iff (!rst_n)
      1'b1 |=> pend_q == 16'({$past(irq_src), 1'b0})); // R1
   AST_CTL_BYTE_WR: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_wr && !bus_word && bus_addr == CTL_BASE) |=> ctl_q[1] == $past(bus_wdata[7:0])); // R10
   AST_MASK_RSVD: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_wr && bus_word && bus_addr[7:1] == MASK_OFF[7:1]) |=> mask_q[0] == 1'b0); // R2
endmodule

// File: rtl/pvi_arbiter.sv
module pvi_arbiter
   import pvi_pkg::*;
#(
   parameter int NUM_SRC = 13
) (
   input  logic                  clk,
   input  logic                  rst_n,
   input  logic [NUM_SRC:1]      irq_src,
   input  logic [NUM_SRC:1]      mask,
   input  logic [NUM_SRC:1][7:0] ctl,
   output logic                  win_valid,
   output logic [3:0]            win_idx,
   output logic                  win_auto,
   output logic [2:0]            win_lvl
);
   logic [4:0] rank [1:NUM_SRC];
   logic [4:0] best;
   logic [7:0] best_ctl;

   for (genvar g = 1; g <= NUM_SRC; g++) begin : g_rank
      assign rank[g] = (irq_src[g] && !mask[g]) ? ctl[g][4:0] : 5'd0;

      AST_RANK_MAX: assert property (@(posedge clk) disable iff (!rst_n)
         win_valid |-> best >= rank[g]); // R3
      AST_TIE_LOW: assert property (@(posedge clk) disable iff (!rst_n)
         (win_valid && rank[g] == best) |-> win_idx <= 4'(g)); // R4
   end

   // strict compare keeps the lowest-numbered source on a tie
   always_comb begin
      best     = 5'd0;
      best_ctl = 8'h00;
      win_idx  = 4'd0;
      for (int i = 1; i <= NUM_SRC; i++) begin
         if (rank[i] > best) begin
            best     = rank[i];
            best_ctl = ctl[i];
            win_idx  = 4'(i);
         end
      end
   end

   assign win_valid = best >= MIN_RANK;
   assign win_auto  = best_ctl[7];
   assign win_lvl   = best_ctl[4:2];

   AST_WIN_UNMASKED: assert property (@(posedge clk) disable iff (!rst_n)
      win_valid |-> (irq_src[win_idx] && !mask[win_idx])); // R2
endmodule

// File: rtl/pvi_vector.sv
module pvi_vector
   import pvi_pkg::*;
#(
   parameter int WDOG_SRC  = 8,
   parameter int UART0_SRC = 12,
   parameter int UART1_SRC = 13
) (
   input  logic       clk,
   input  logic       rst_n,
   input  logic       win_valid,
   input  logic [3:0] win_idx,
   input  logic       win_auto,
   input  logic [2:0] win_lvl,
   input  logic [7:0] wdog_vec,
   input  logic [7:0] uart0_vec,
   input  logic [7:0] uart1_vec,
   output logic [2:0] irq_level,
   output logic [7:0] irq_vector
);
   logic [7:0] vec_n;

   always_comb begin
      if (!win_valid)                     vec_n = 8'h00;
      else if (win_auto)                  vec_n = AUTO_BASE + 8'(win_lvl);
      else if (win_idx == 4'(WDOG_SRC))   vec_n = wdog_vec;
      else if (win_idx == 4'(UART0_SRC))  vec_n = uart0_vec;
      else if (win_idx == 4'(UART1_SRC))  vec_n = uart1_vec;
      else                                vec_n = DFLT_VEC;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         irq_level  <= 3'd0;
         irq_vector <= 8'h00;
      end else begin
         irq_level  <= win_valid ? win_lvl : 3'd0;
         irq_vector <= vec_n;
      end
   end

   AST_IDLE_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
      irq_level == 3'd0 |-> irq_vector == 8'h00); // R5
   AST_AUTOVEC: assert property (@(posedge clk) disable iff (!rst_n)
      (win_valid && win_auto) |=> irq_vector == AUTO_BASE + 8'(irq_level)); // R6
   AST_WDOG_VEC: assert property (@(posedge clk) disable iff (!rst_n)
      (win_valid && !win_auto && win_idx == 4'(WDOG_SRC)) |=> irq_vector == $past(wdog_vec)); // R7
   AST_DROP_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
      !win_valid |=> (irq_level == 3'd0 && irq_vector == 8'h00)); // R9
endmodule

// File: rtl/prio_vec_intc.sv
module prio_vec_intc
   import pvi_pkg::*;
#(
   parameter int NUM_SRC   = 13,
   parameter int WDOG_SRC  = 8,
   parameter int UART0_SRC = 12,
   parameter int UART1_SRC = 13
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic                 bus_wr,
   input  logic                 bus_word,
   input  logic [7:0]           bus_addr,
   input  logic [15:0]          bus_wdata,
   output logic [15:0]          bus_rdata,
   input  logic [NUM_SRC:1]     irq_src,
   output logic [2:0]           irq_level,
   output logic [7:0]           irq_vector
);
   if (NUM_SRC < 1 || NUM_SRC > MAX_SRC) begin : g_bad_num
      $error("NUM_SRC must lie in 1..15");
   end
   if (WDOG_SRC < 1 || WDOG_SRC > NUM_SRC || UART0_SRC < 1 || UART0_SRC > NUM_SRC ||
       UART1_SRC < 1 || UART1_SRC > NUM_SRC) begin : g_bad_map
      $error("programmable-vector source numbers must name existing sources");
   end
   if (WDOG_SRC == UART0_SRC || WDOG_SRC == UART1_SRC || UART0_SRC == UART1_SRC) begin : g_dup_map
      $error("programmable-vector sources must be distinct");
   end

   logic [NUM_SRC:1][7:0] ctl_w;
   logic [NUM_SRC:1]      mask_w;
   logic [7:0]            wdv_w, u0v_w, u1v_w;
   logic                  win_valid, win_auto;
   logic [3:0]            win_idx;
   logic [2:0]            win_lvl;

   pvi_regs #(.NUM_SRC(NUM_SRC)) u_regs (
      .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_word(bus_word),
      .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
      .irq_src(irq_src), .ctl(ctl_w), .mask(mask_w),
      .wdog_vec(wdv_w), .uart0_vec(u0v_w), .uart1_vec(u1v_w)
   );

   pvi_arbiter #(.NUM_SRC(NUM_SRC)) u_arb (
      .clk(clk), .rst_n(rst_n), .irq_src(irq_src), .mask(mask_w), .ctl(ctl_w),
      .win_valid(win_valid), .win_idx(win_idx), .win_auto(win_auto), .win_lvl(win_lvl)
   );

   pvi_vector #(.WDOG_SRC(WDOG_SRC), .UART0_SRC(UART0_SRC), .UART1_SRC(UART1_SRC)) u_vec (
      .clk(clk), .rst_n(rst_n), .win_valid(win_valid), .win_idx(win_idx),
      .win_auto(win_auto), .win_lvl(win_lvl), .wdog_vec(wdv_w),
      .uart0_vec(u0v_w), .uart1_vec(u1v_w),
      .irq_level(irq_level), .irq_vector(irq_vector)
   );
endmodule

// File: tb/prio_vec_intc_bench.sv
`timescale 1ns/1ps
module prio_vec_intc_bench;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        bus_wr = 1'b0;
   logic        bus_word = 1'b0;
   logic [7:0]  bus_addr = 8'h00;
   logic [15:0] bus_wdata = 16'h0000;
   logic [15:0] bus_rdata;
   logic [13:1] irq_src = '0;
   logic [2:0]  irq_level;
   logic [7:0]  irq_vector;

   int vectors = 0;
   int miscompares = 0;
   bit done = 1'b0;

   // behavioural model state
   logic [7:0]  m_ctl [1:13];
   logic [15:0] m_mask;
   logic [7:0]  m_wv, m_u0, m_u1;
   logic [13:1] m_srcq;

   always #2.5 clk = ~clk;

   prio_vec_intc u_prio_vec_intc (
      .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_word(bus_word),
      .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
      .irq_src(irq_src), .irq_level(irq_level), .irq_vector(irq_vector)
   );

   function automatic logic [13:1] src_bit(input int n);
      return 13'(1) << (n - 1);
   endfunction

   task automatic check(input string req, input logic [15:0] act, input logic [15:0] exp);
      vectors++;
      if (act !== exp) begin
         miscompares++;
         $display("FAIL %s: actual %h expected %h at %0t", req, act, exp, $time);
      end
   endtask

   task automatic model_reset();
      for (int i = 1; i <= 13; i++) begin
         if (i <= 7)       m_ctl[i] = 8'(i * 4);
         else if (i == 8)  m_ctl[i] = 8'h1C;
         else if (i <= 11) m_ctl[i] = 8'h80;
         else              m_ctl[i] = 8'h00;
      end
      m_mask = 16'h3FFE; m_wv = 8'h0F; m_u0 = 8'h00; m_u1 = 8'h00; m_srcq = '0;
   endtask

   task automatic m_wbyte(input logic [7:0] off, input logic [7:0] d);
      if (off >= 8'h14 && off <= 8'h20) m_ctl[int'(off) - 19] = d;
      else if (off == 8'h36) m_mask[15:8] = d & 8'h3F;
      else if (off == 8'h37) m_mask[7:0]  = d & 8'hFE;
      else if (off == 8'h42) m_wv = d;
      else if (off == 8'h44) m_u0 = d;
      else if (off == 8'h45) m_u1 = d;
   endtask

   function automatic logic [7:0] m_rbyte(input logic [7:0] off);
      logic [15:0] p;
      p = {2'b00, m_srcq, 1'b0};
      if (off >= 8'h14 && off <= 8'h20) return m_ctl[int'(off) - 19];
      if (off == 8'h36) return m_mask[15:8];
      if (off == 8'h37) return m_mask[7:0];
      if (off == 8'h3A) return p[15:8];
      if (off == 8'h3B) return p[7:0];
      if (off == 8'h42) return m_wv;
      if (off == 8'h44) return m_u0;
      if (off == 8'h45) return m_u1;
      return 8'h00;
   endfunction

   function automatic logic [15:0] m_expect(input logic [13:1] src);
      int best, w;
      logic [2:0] lvl;
      logic [7:0] vec;
      best = 0; w = 0;
      for (int i = 1; i <= 13; i++)
         if (src[i] && !m_mask[i] && int'(m_ctl[i][4:0]) > best) begin
            best = int'(m_ctl[i][4:0]); w = i;
         end
      if (best < 4) return 16'h0000;
      lvl = m_ctl[w][4:2];
      if (m_ctl[w][7])  vec = 8'd24 + 8'(lvl);
      else if (w == 8)  vec = m_wv;
      else if (w == 12) vec = m_u0;
      else if (w == 13) vec = m_u1;
      else              vec = 8'h0F;
      return {5'b0, lvl, vec};
   endfunction

   // one clock: drive at negedge, compare just after the edge
   task automatic cycle(input logic wr, input logic word, input logic [7:0] addr,
                        input logic [15:0] data, input logic [13:1] src, input string req);
      logic [15:0] exp;
      bus_wr = wr; bus_word = word; bus_addr = addr; bus_wdata = data; irq_src = src;
      exp = m_expect(src);
      @(posedge clk);
      if (wr) begin
         if (word) begin
            m_wbyte({addr[7:1], 1'b0}, data[15:8]);
            m_wbyte({addr[7:1], 1'b1}, data[7:0]);
         end else m_wbyte(addr, data[7:0]);
      end
      m_srcq = src;
      #1;
      bus_wr = 1'b0;
      check(req, {5'b0, irq_level, irq_vector}, exp);
      @(negedge clk);
   endtask

   task automatic rd_check(input logic word, input logic [7:0] addr, input string req);
      logic [15:0] exp;
      bus_wr = 1'b0; bus_word = word; bus_addr = addr;
      #1;
      exp = word ? {m_rbyte({addr[7:1], 1'b0}), m_rbyte({addr[7:1], 1'b1})} : {8'h00, m_rbyte(addr)};
      check(req, bus_rdata, exp);
   endtask

   initial begin
      for (int n = 0; n < 20000 && !done; n++) @(posedge clk);
      if (!done) begin
         miscompares++;
         $display("FAIL watchdog: actual hung expected finish");
         $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
         $finish;
      end
   end

   initial begin
      model_reset();
      repeat (3) @(posedge clk);
      #1;
      check("R9 reset outputs", {5'b0, irq_level, irq_vector}, 16'h0000);
      @(negedge clk);
      rst_n = 1'b1;
      // R8 reset control bytes, R2 mask reset, R7 vector resets, R1 pending idle
      for (int a = 8'h14; a <= 8'h20; a++) rd_check(1'b0, 8'(a), "R8");
      rd_check(1'b1, 8'h36, "R2");
      rd_check(1'b0, 8'h42, "R7");
      rd_check(1'b0, 8'h44, "R7");
      rd_check(1'b1, 8'h3A, "R1");

      cycle(0, 0, 8'h00, 16'h0, '1, "R2 all masked");
      cycle(1, 1, 8'h36, 16'h0000, '1, "R2 unmask");
      cycle(0, 0, 8'h00, 16'h0, '1, "R4 tie src7 src8");
      rd_check(1'b1, 8'h3A, "R1 pending");
      cycle(1, 1, 8'h3A, 16'h0000, '1, "R1 write ignored");
      rd_check(1'b1, 8'h3B, "R1 pending after write");
      cycle(1, 1, 8'h36, 16'hFFFF, '1, "R2 mask all");
      rd_check(1'b1, 8'h36, "R2 reserved bits");
      cycle(0, 0, 8'h00, 16'h0, '1, "R2 blocked");
      cycle(1, 0, 8'h37, 16'h0040, src_bit(6), "R10 byte lane mask");
      rd_check(1'b1, 8'h36, "R10 mask word");
      cycle(1, 1, 8'h36, 16'h0000, src_bit(6), "R3 single");
      cycle(0, 0, 8'h00, 16'h0, src_bit(6), "R3 src6");
      cycle(0, 0, 8'h00, 16'h0, src_bit(8), "R7 wdog default");
      cycle(1, 0, 8'h42, 16'h0055, src_bit(8), "R7 wdog write");
      cycle(0, 0, 8'h00, 16'h0, src_bit(8), "R7 wdog programmed");
      cycle(0, 0, 8'h00, 16'h0, src_bit(1), "R5 rank 4 boundary");
      cycle(0, 0, 8'h00, 16'h0, src_bit(9), "R5 rank 0");
      cycle(1, 0, 8'h14, 16'h0003, src_bit(1), "R10 byte ctl");
      cycle(0, 0, 8'h00, 16'h0, src_bit(1), "R5 rank 3");
      cycle(1, 0, 8'h1C, 16'h0093, src_bit(9), "R6 set auto");
      cycle(0, 0, 8'h00, 16'h0, src_bit(9), "R6 autovector");
      cycle(1, 0, 8'h44, 16'h0040, '0, "R7 uart0 vec");
      cycle(1, 0, 8'h45, 16'h0041, '0, "R7 uart1 vec");
      cycle(1, 0, 8'h1F, 16'h000B, '0, "R3 ctl12");
      cycle(1, 0, 8'h20, 16'h000B, '0, "R3 ctl13");
      cycle(0, 0, 8'h00, 16'h0, src_bit(12) | src_bit(13), "R4 tie src12 src13");
      cycle(0, 0, 8'h00, 16'h0, src_bit(13), "R7 uart1 source");
      cycle(1, 1, 8'h15, 16'h0E0D, '0, "R10 word odd addr");
      rd_check(1'b1, 8'h14, "R10 word read");
      rd_check(1'b0, 8'h15, "R10 byte read");
      rd_check(1'b1, 8'h50, "R10 unmapped");
      cycle(0, 0, 8'h00, 16'h0, src_bit(1) | src_bit(2), "R3 sub-priority");
      cycle(0, 0, 8'h00, 16'h0, src_bit(2) | src_bit(13), "R3 sub-priority vs src13");

      for (int n = 0; n < 600; n++) begin
         logic [31:0] r;
         logic [7:0]  a;
         r = $urandom;
         case (r[2:0])
            3'd0: a = 8'h36;
            3'd1: a = 8'h42;
            3'd2: a = 8'h44 + 8'(r[3]);
            default: a = 8'h14 + 8'(r[7:4] % 13);
         endcase
         cycle(r[10] & r[11], r[12], a, 16'(r[31:16]), 13'($urandom), "R3 R9 sweep");
         if (r[13]) rd_check(r[14], 8'($urandom % 80), "R10 sweep read");
      end

      done = 1'b1;
      $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
      $finish;
   end
endmodule